// File: doc/BRIEF.md
# Random Memory Traffic Checker

This block drives a pseudo-random mix of reads and writes at a memory port under test and checks that the port behaves like plain memory. It chooses each request's command, target region, access size and offset from free-running shift-register generators. It keeps its own shadow image of the three memory regions. A write updates the shadow when the write is issued. A read copies its expected bytes out of the shadow when it is issued and parks them in a small tag-indexed table. When the response arrives, the returned bytes are compared with the parked copy.

Two of the regions are cacheable. The third is marked uncacheable on the request. After reset the block runs in state FILL. In FILL it loads the shadow one word per cycle: byte value 0x01 into region A, 0x02 into region B and 0x03 into the uncacheable region. It then takes transition FILL->RUN and stays in RUN until the next reset, issuing traffic. The memory under test must start with the same contents.

Around the traffic there are the following observers:
- a sticky data-mismatch flag;
- a no-response watchdog that raises a sticky deadlock flag;
- counters of completed reads and writes;
- a pulse each time the completed-read count reaches the next multiple of a programmable interval;
- a flag for accesses that touch one chosen block.

Top module: `mem_traffic_checker`

## Requirements
- R1: While reset is high, and for the 3*REGION_BYTES/8 cycles of state FILL that follow it, `req_valid` stays low. The counters and all flags read zero. On the next cycle, if the port is not blocked, a request is offered.
- R2: A request is a read when a draw in 0..99 is below READ_PCT (default 65). Otherwise it is a write (`req_write`=1). Over a long run the read share lies between 55% and 75%.
- R3: A request goes to the uncacheable region (base BASE_UC) with `req_uncache`=1 when a second draw in 0..99 is below UC_PCT (default 10). Otherwise it goes to region A or region B, chosen at random, with `req_uncache`=0. Both cacheable regions are used.
- R4: `req_size` encodes 2^req_size bytes (0:1, 1:2, 2:4, 3:8). `req_addr` is aligned to that size. The whole access lies inside its region of REGION_BYTES bytes.
- R5: The returned data is right-justified in `rsp_data` (byte i in bits 8i+7:8i), and so is the write data in `req_wdata`. When the memory returns correct data, which starts as 0x01, 0x02 or 0x03 per region and reflects all earlier writes in issue order, `mismatch_err` stays low.
- R6: A read response whose low 2^size bytes differ from the expected bytes sets `mismatch_err` on the next cycle. The flag then stays set until reset. Differences in bytes above the access size have no effect.
- R7: At most four requests are outstanding, each with a distinct 2-bit `req_tag`. With four outstanding, no request is offered.
- R8: In a cycle where `port_blocked` is high, `req_valid` is low.
- R9: A request that is offered but not accepted (`req_ready` low) is offered again unchanged the next time `req_valid` is high.
- R10: `rd_count` and `wr_count` advance by one in the cycle after each read or write response, respectively.
- R11: `progress_pulse` is high for one cycle after the read response that brings `rd_count` to a multiple of `prog_interval`.
- R12: `trace_hit` is high in the cycle after any accepted request, or any response, whose address matches `trace_addr` with the low log2(BLOCK_BYTES) bits ignored.
- R13: A no-response counter counts every cycle after reset, including cycles where the port is blocked, and clears on each response. In the cycle after the counter reaches DEAD_LIMIT (default 5000), `deadlock_err` rises and stays set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| port_blocked | input | 1 | Port under test cannot take a request this cycle |
| req_ready | input | 1 | Port accepts the offered request |
| req_valid | output | 1 | Request offered |
| req_write | output | 1 | 1 = write, 0 = read |
| req_uncache | output | 1 | Request targets the uncacheable region |
| req_addr | output | 32 | Byte address, size-aligned |
| req_size | output | 2 | log2 of access bytes |
| req_wdata | output | 64 | Write data, right-justified |
| req_tag | output | 2 | Tag of the offered request |
| rsp_valid | input | 1 | Response present |
| rsp_tag | input | 2 | Tag of the completed request |
| rsp_data | input | 64 | Read data, right-justified |
| prog_interval | input | 32 | Completed reads between progress pulses |
| trace_addr | input | 32 | Address whose block is traced |
| mismatch_err | output | 1 | Sticky data mismatch |
| deadlock_err | output | 1 | Sticky no-response timeout |
| progress_pulse | output | 1 | Read-progress pulse |
| trace_hit | output | 1 | Traced block was touched |
| rd_count | output | 32 | Completed reads |
| wr_count | output | 32 | Completed writes |

## Verification
The embedded properties watch the following on every cycle:
- silence during FILL and while the port is blocked;
- size alignment of every offered address;
- an unaccepted request is held unchanged;
- no allocation into a full tag table;
- stickiness of both error flags;
- counters that move only after a response.

Only the bench's scenarios can show that the data really matches a memory that starts from the three fill patterns. The same holds for the statistical read and uncacheable shares, for bytes above the access size being ignored, and for the exact watchdog and progress-pulse cycles. The bench shows these by acting as the memory under test, with random stalls, random blocking and out-of-order responses.

// File: rtl/mtc_pkg.sv
package mtc_pkg;
    parameter int AW = 32;
    parameter int DW = 64;

    typedef enum logic [0:0] {ST_FILL, ST_RUN} mtc_state_e;

    typedef struct packed {
        logic          rd;
        logic [1:0]    size_log;
        logic [AW-1:0] addr;
        logic [DW-1:0] exp_d;
    } mtc_entry_t;

    // byte enables for an access of 2^s bytes, right-justified
    function automatic logic [DW/8-1:0] byte_en(input logic [1:0] s);
        logic [DW/8-1:0] m;
        for (int i = 0; i < DW/8; i++) m[i] = (i < (1 << s));
        return m;
    endfunction

    // bit mask over the low 2^s bytes
    function automatic logic [DW-1:0] size_mask(input logic [1:0] s);
        logic [DW-1:0] m;
        for (int i = 0; i < DW/8; i++) m[i*8 +: 8] = (i < (1 << s)) ? 8'hFF : 8'h00;
        return m;
    endfunction
endpackage

// File: rtl/mtc_lfsr.sv
module mtc_lfsr #(
    parameter int          W    = 32,
    parameter logic [W-1:0] SEED = W'(32'h1ACE_B00C),
    parameter logic [W-1:0] TAPS = W'(32'h8020_0003)
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         step,
    output logic [W-1:0] value
);
    always_ff @(posedge clk) begin
        if (rst)       value <= SEED;
        else if (step) value <= value[0] ? ((value >> 1) ^ TAPS) : (value >> 1);
    end

    // R2
    lfsr_live_chk: assert property (@(posedge clk) disable iff (rst) value != '0);
endmodule

// File: rtl/mtc_shadow.sv
module mtc_shadow #(
    parameter int WORDS = 96,
    parameter int IW    = $clog2(WORDS),
    parameter int DW    = 64
) (
    input  logic            clk,
    input  logic            we,
    input  logic [IW-1:0]   widx,
    input  logic [DW/8-1:0] wbe,
    input  logic [DW-1:0]   wdata,
    input  logic [IW-1:0]   ridx,
    output logic [DW-1:0]   rdata
);
    logic [DW-1:0] mem [WORDS];

    always_ff @(posedge clk) begin
        if (we) begin
            for (int b = 0; b < DW/8; b++)
                if (wbe[b]) mem[widx][b*8 +: 8] <= wdata[b*8 +: 8];
        end
    end

    assign rdata = mem[ridx];

    // R5
    shadow_idx_chk: assert property (@(posedge clk) we |-> (int'(widx) < WORDS));
endmodule

// File: rtl/mtc_tag_table.sv
module mtc_tag_table
    import mtc_pkg::*;
#(
    parameter int TW    = 2,
    parameter int DEPTH = 1 << TW
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          alloc,
    input  mtc_entry_t    alloc_d,
    output logic [TW-1:0] alloc_tag,
    output logic          full,
    input  logic          rel,
    input  logic [TW-1:0] look_tag,
    output logic          look_valid,
    output mtc_entry_t    look_d
);
    logic [DEPTH-1:0] v_vec;
    mtc_entry_t       d_arr [DEPTH];

    for (genvar g = 0; g < DEPTH; g++) begin : g_ent
        logic       v;
        mtc_entry_t d;
        always_ff @(posedge clk) begin
            if (rst) begin
                v <= 1'b0;
            end else if (alloc && alloc_tag == TW'(g)) begin
                v <= 1'b1;
                d <= alloc_d;
            end else if (rel && look_tag == TW'(g)) begin
                v <= 1'b0;
            end
        end
        assign v_vec[g] = v;
        assign d_arr[g] = d;
    end

    always_comb begin
        logic found;
        found     = 1'b0;
        alloc_tag = '0;
        for (int i = 0; i < DEPTH; i++) begin
            if (!v_vec[i] && !found) begin
                alloc_tag = TW'(i);
                found     = 1'b1;
            end
        end
    end

    assign full       = &v_vec;
    assign look_valid = v_vec[look_tag];
    assign look_d     = d_arr[look_tag];

    // R7
    alloc_room_chk: assert property (@(posedge clk) disable iff (rst) alloc |-> !full);
endmodule

// File: rtl/mem_traffic_checker.sv
module mem_traffic_checker
    import mtc_pkg::*;
#(
    parameter int          READ_PCT     = 65,
    parameter int          UC_PCT       = 10,
    parameter int          REGION_BYTES = 256,
    parameter int          BLOCK_BYTES  = 64,
    parameter logic [31:0] BASE_A       = 32'h0010_0000,
    parameter logic [31:0] BASE_B       = 32'h0040_0000,
    parameter logic [31:0] BASE_UC      = 32'h0080_0000,
    parameter int          DEAD_LIMIT   = 5000,
    parameter int          CNT_W        = 32,
    parameter int          TAG_W        = 2,
    parameter logic [31:0] SEED         = 32'h1ACE_B00C
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             port_blocked,
    input  logic             req_ready,
    output logic             req_valid,
    output logic             req_write,
    output logic             req_uncache,
    output logic [AW-1:0]    req_addr,
    output logic [1:0]       req_size,
    output logic [DW-1:0]    req_wdata,
    output logic [TAG_W-1:0] req_tag,
    input  logic             rsp_valid,
    input  logic [TAG_W-1:0] rsp_tag,
    input  logic [DW-1:0]    rsp_data,
    input  logic [CNT_W-1:0] prog_interval,
    input  logic [AW-1:0]    trace_addr,
    output logic             mismatch_err,
    output logic             deadlock_err,
    output logic             progress_pulse,
    output logic             trace_hit,
    output logic [CNT_W-1:0] rd_count,
    output logic [CNT_W-1:0] wr_count
);
    localparam int LANE_W = $clog2(DW/8);
    localparam int OFF_W  = $clog2(REGION_BYTES);
    localparam int WPR    = REGION_BYTES / (DW/8);
    localparam int WORDS  = 3 * WPR;
    localparam int IW     = $clog2(WORDS);
    localparam int WD_W   = $clog2(DEAD_LIMIT + 1);
    localparam logic [AW-1:0] BLK_MASK = ~AW'(BLOCK_BYTES - 1);

    mtc_state_e state, state_nx;
    logic [IW-1:0]  fill_idx;
    logic [31:0]    ctl_q, sel_q, dat_q;
    logic           fire;

    // ---------------- random sources ----------------
    mtc_lfsr #(.W(32), .SEED(SEED))                 u_ctl (.clk(clk), .rst(rst), .step(fire), .value(ctl_q));
    mtc_lfsr #(.W(32), .SEED(SEED ^ 32'h5A5A_1234)) u_sel (.clk(clk), .rst(rst), .step(fire), .value(sel_q));
    mtc_lfsr #(.W(32), .SEED(SEED ^ 32'h0F0F_F0F1)) u_dat (.clk(clk), .rst(rst), .step(fire), .value(dat_q));

    logic [15:0]      cmd_draw, uc_draw;
    logic             is_rd, is_uc;
    logic [1:0]       region, size_log;
    logic [OFF_W-1:0] size_low, off_al;
    logic [AW-1:0]    base;
    logic [LANE_W-1:0] lane;
    logic [IW-1:0]    widx_run;
    logic [DW-1:0]    wdata_run;

    assign cmd_draw = ctl_q[15:0] % 16'd100;
    assign uc_draw  = ctl_q[31:16] % 16'd100;
    assign is_rd    = cmd_draw < 16'(READ_PCT);
    assign is_uc    = uc_draw < 16'(UC_PCT);
    assign region   = is_uc ? 2'd2 : {1'b0, sel_q[2]};
    assign size_log = sel_q[1:0];
    assign size_low = OFF_W'((32'd1 << size_log) - 32'd1);
    assign off_al   = sel_q[3 +: OFF_W] & ~size_low;
    assign lane     = off_al[LANE_W-1:0];
    assign widx_run = IW'(region) * IW'(WPR) + IW'(off_al >> LANE_W);
    assign wdata_run = {dat_q, dat_q ^ sel_q};

    always_comb begin
        case (region)
            2'd0:    base = BASE_A;
            2'd1:    base = BASE_B;
            default: base = BASE_UC;
        endcase
    end

    // ---------------- shadow store and tag table ----------------
    logic            sh_we;
    logic [IW-1:0]   sh_widx;
    logic [DW/8-1:0] sh_wbe;
    logic [DW-1:0]   sh_wdata, sh_rdata, exp_d;
    logic [7:0]      fill_byte;

    assign fill_byte = (fill_idx >= IW'(2*WPR)) ? 8'h03 :
                       (fill_idx >= IW'(WPR))   ? 8'h02 : 8'h01;

    mtc_shadow #(.WORDS(WORDS), .IW(IW), .DW(DW)) u_shadow (
        .clk(clk), .we(sh_we), .widx(sh_widx), .wbe(sh_wbe), .wdata(sh_wdata),
        .ridx(widx_run), .rdata(sh_rdata)
    );
    assign exp_d = sh_rdata >> {lane, 3'b000};

    mtc_entry_t new_ent, look_d;
    logic       tab_full, look_valid, done;

    always_comb begin
        new_ent.rd       = is_rd;
        new_ent.size_log = size_log;
        new_ent.addr     = req_addr;
        new_ent.exp_d    = exp_d;
    end

    mtc_tag_table #(.TW(TAG_W)) u_tab (
        .clk(clk), .rst(rst), .alloc(fire), .alloc_d(new_ent), .alloc_tag(req_tag),
        .full(tab_full), .rel(done), .look_tag(rsp_tag), .look_valid(look_valid), .look_d(look_d)
    );
    assign done = rsp_valid && look_valid;

    // ---------------- state machine ----------------
    always_ff @(posedge clk) begin
        if (rst) state <= ST_FILL;
        else     state <= state_nx;
    end

    always_comb begin
        unique case (state)
            ST_FILL: state_nx = (fill_idx == IW'(WORDS - 1)) ? ST_RUN : ST_FILL;
            ST_RUN:  state_nx = ST_RUN;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst)                  fill_idx <= '0;
        else if (state == ST_FILL) fill_idx <= fill_idx + 1'b1;
    end

    always_comb begin
        req_valid = 1'b0;
        sh_we     = 1'b0;
        sh_widx   = widx_run;
        sh_wbe    = byte_en(size_log) << lane;
        sh_wdata  = wdata_run << {lane, 3'b000};
        unique case (state)
            ST_FILL: begin
                sh_we    = 1'b1;
                sh_widx  = fill_idx;
                sh_wbe   = '1;
                sh_wdata = {(DW/8){fill_byte}};
            end
            ST_RUN: begin
                req_valid = !port_blocked && !tab_full;
                sh_we     = req_valid && req_ready && !is_rd;
            end
        endcase
    end

    assign fire        = req_valid && req_ready;
    assign req_write   = !is_rd;
    assign req_uncache = is_uc;
    assign req_addr    = base + AW'(off_al);
    assign req_size    = size_log;
    assign req_wdata   = wdata_run;

    // ---------------- observers ----------------
    logic [CNT_W-1:0] next_mark;
    logic [WD_W-1:0]  wd_cnt;

    always_ff @(posedge clk) begin
        if (rst) begin
            rd_count <= '0; wr_count <= '0; next_mark <= '0;
            progress_pulse <= 1'b0; mismatch_err <= 1'b0; deadlock_err <= 1'b0;
            wd_cnt <= '0; trace_hit <= 1'b0;
        end else begin
            progress_pulse <= 1'b0;
            if (state == ST_FILL) next_mark <= prog_interval;
            if (done) begin
                if (look_d.rd) begin
                    rd_count <= rd_count + 1'b1;
                    if (rd_count + 1'b1 == next_mark) begin
                        progress_pulse <= 1'b1;
                        next_mark      <= next_mark + prog_interval;
                    end
                    if (((rsp_data ^ look_d.exp_d) & size_mask(look_d.size_log)) != '0)
                        mismatch_err <= 1'b1;
                end else begin
                    wr_count <= wr_count + 1'b1;
                end
            end
            if (done)                             wd_cnt <= '0;
            else if (wd_cnt != WD_W'(DEAD_LIMIT)) wd_cnt <= wd_cnt + 1'b1;
            if (!done && wd_cnt == WD_W'(DEAD_LIMIT - 1)) deadlock_err <= 1'b1;
            trace_hit <= (fire && ((req_addr & BLK_MASK) == (trace_addr & BLK_MASK))) ||
                         (done && ((look_d.addr & BLK_MASK) == (trace_addr & BLK_MASK)));
        end
    end

    // R1
    fill_quiet_chk: assert property (@(posedge clk) disable iff (rst) (state == ST_FILL) |-> !req_valid);
    // R8
    blocked_quiet_chk: assert property (@(posedge clk) disable iff (rst) port_blocked |-> !req_valid);
    // R4
    size_align_chk: assert property (@(posedge clk) disable iff (rst)
        req_valid |-> ((req_addr & ((AW'(1) << req_size) - AW'(1))) == '0));
    // R9
    hold_req_chk: assert property (@(posedge clk) disable iff (rst)
        (req_valid && !req_ready) |=> (!req_valid || ($stable(req_addr) && $stable(req_write) && $stable(req_size))));
    // R6
    mismatch_sticky_chk: assert property (@(posedge clk) disable iff (rst) mismatch_err |=> mismatch_err);
    // R13
    deadlock_sticky_chk: assert property (@(posedge clk) disable iff (rst) deadlock_err |=> deadlock_err);
    // R11
    pulse_on_read_chk: assert property (@(posedge clk) disable iff (rst)
        progress_pulse |-> (rd_count == $past(rd_count) + 1'b1));
    // R10
    count_quiet_chk: assert property (@(posedge clk) disable iff (rst)
        !$past(rsp_valid) |-> ($stable(rd_count) && $stable(wr_count)));
endmodule

// File: tb/sim_mem_traffic_checker.sv
`timescale 1ns/1ps
module sim_mem_traffic_checker;
    localparam logic [31:0] BA = 32'h0010_0000, BB = 32'h0040_0000, BU = 32'h0080_0000;
    localparam int REG = 256, LIMIT = 5000, IVL = 7;
    localparam logic [31:0] TRACE = BA + 32'h40;

    logic clk = 1'b0;
    always #2.5 clk = ~clk;

    logic rst, port_blocked, req_ready, rsp_valid;
    logic [1:0] rsp_tag;
    logic [63:0] rsp_data;
    logic [31:0] prog_interval, trace_addr;
    logic req_valid, req_write, req_uncache, mismatch_err, deadlock_err, progress_pulse, trace_hit;
    logic [31:0] req_addr, rd_count, wr_count;
    logic [1:0] req_size, req_tag;
    logic [63:0] req_wdata;

    mem_traffic_checker #(.REGION_BYTES(REG), .BASE_A(BA), .BASE_B(BB), .BASE_UC(BU), .DEAD_LIMIT(LIMIT)) u0 (
        .clk(clk), .rst(rst), .port_blocked(port_blocked), .req_ready(req_ready),
        .req_valid(req_valid), .req_write(req_write), .req_uncache(req_uncache), .req_addr(req_addr),
        .req_size(req_size), .req_wdata(req_wdata), .req_tag(req_tag), .rsp_valid(rsp_valid),
        .rsp_tag(rsp_tag), .rsp_data(rsp_data), .prog_interval(prog_interval), .trace_addr(trace_addr),
        .mismatch_err(mismatch_err), .deadlock_err(deadlock_err), .progress_pulse(progress_pulse),
        .trace_hit(trace_hit), .rd_count(rd_count), .wr_count(wr_count));

    int tests = 0, fails = 0;
    bit finished = 1'b0;
    logic [7:0] mem [3*REG];
    bit pend_v [4]; bit pend_rd [4]; logic [63:0] pend_d [4]; logic [31:0] pend_a [4]; logic [1:0] pend_s [4];
    int bench_rd = 0, bench_wr = 0, idle = 1, n_fire = 0, n_rd = 0, n_uc = 0, n_a = 0, n_b = 0;
    int n_pulse = 0, n_trace = 0, n_above = 0;
    bit exp_mis = 0, exp_dead = 0, exp_pulse = 0, exp_trace = 0, corrupted = 0;
    bit prev_wait = 0, prev_wr = 0; logic [31:0] prev_addr = '0;

    task automatic chk(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] expv);
        tests++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, expv);
        end
    endtask

    function automatic int midx(input logic [31:0] a);
        if (a >= BU) return 2*REG + int'(a - BU);
        if (a >= BB) return REG + int'(a - BB);
        return int'(a - BA);
    endfunction

    // one cycle: check outputs of last edge, drive, act as memory
    task automatic step(input int rsp_pct, input int blk_pct, input int mode);
        int t, npend, sz;
        logic [63:0] d;
        bit n_mis, n_dead, n_pul, n_trc;
        @(negedge clk);
        chk(rd_count == 32'(bench_rd), "R10 rd_count", rd_count, bench_rd);
        chk(wr_count == 32'(bench_wr), "R10 wr_count", wr_count, bench_wr);
        chk(mismatch_err == exp_mis, "R6 mismatch_err", mismatch_err, exp_mis);
        chk(deadlock_err == exp_dead, "R13 deadlock_err", deadlock_err, exp_dead);
        chk(progress_pulse == exp_pulse, "R11 progress_pulse", progress_pulse, exp_pulse);
        chk(trace_hit == exp_trace, "R12 trace_hit", trace_hit, exp_trace);
        if (progress_pulse) n_pulse++;
        if (trace_hit) n_trace++;
        port_blocked = ($urandom_range(99) < blk_pct);
        req_ready = ($urandom_range(99) < 75);
        rsp_valid = 1'b0; rsp_tag = '0; rsp_data = '0;
        #1;
        n_mis = exp_mis; n_pul = 0; n_trc = 0; t = -1; npend = 0;
        for (int i = 0; i < 4; i++) if (pend_v[i]) npend++;
        if (mode != 3 && $urandom_range(99) < rsp_pct) begin
            int s0 = $urandom_range(3);
            for (int i = 0; i < 4; i++) if (t < 0 && pend_v[(s0 + i) % 4]) t = (s0 + i) % 4;
        end
        if (t >= 0) begin
            d = pend_d[t];
            if (pend_rd[t]) begin
                if (mode == 1 && pend_s[t] < 2'd3) begin d[8 * (1 << pend_s[t])] = ~d[8 * (1 << pend_s[t])]; n_above++; end
                if (mode == 2 && !corrupted) begin d[0] = ~d[0]; corrupted = 1; n_mis = 1; end
                bench_rd++;
                if (bench_rd % IVL == 0) n_pul = 1;
            end else bench_wr++;
            if (((pend_a[t] ^ TRACE) & ~32'd63) == 0) n_trc = 1;
            rsp_valid = 1'b1; rsp_tag = 2'(t); rsp_data = d;
        end
        n_dead = exp_dead | (!rsp_valid && idle == LIMIT - 1);
        idle = rsp_valid ? 0 : ((idle < LIMIT) ? idle + 1 : idle);
        if (npend == 4) chk(!req_valid, "R7 full table offers nothing", req_valid, 0);
        if (req_valid) begin
            sz = 1 << req_size;
            chk(!port_blocked, "R8 offered while blocked", port_blocked, 0);
            chk((req_addr & 32'(sz - 1)) == 0, "R4 alignment", req_addr, sz);
            chk(((req_addr >= BA && req_addr + 32'(sz) <= BA + REG) || (req_addr >= BB && req_addr + 32'(sz) <= BB + REG) ||
                 (req_addr >= BU && req_addr + 32'(sz) <= BU + REG)), "R4 range", req_addr, 0);
            chk(req_uncache == (req_addr >= BU), "R3 uncache flag", req_uncache, req_addr >= BU);
            if (prev_wait) chk(req_addr == prev_addr && req_write == prev_wr, "R9 held request", req_addr, prev_addr);
            if (req_ready) begin
                chk(!pend_v[req_tag], "R7 distinct tag", req_tag, 0);
                n_fire++;
                if (!req_write) n_rd++;
                if (req_uncache) n_uc++; else if (req_addr >= BB) n_b++; else n_a++;
                d = '0;
                for (int i = 0; i < sz; i++) begin
                    if (req_write) mem[midx(req_addr) + i] = req_wdata[8*i +: 8];
                    else d[8*i +: 8] = mem[midx(req_addr) + i];
                end
                if (((req_addr ^ TRACE) & ~32'd63) == 0) n_trc = 1;
            end
        end
        if (t >= 0) pend_v[t] = 0;
        if (req_valid && req_ready) begin
            pend_v[req_tag] = 1; pend_rd[req_tag] = !req_write; pend_d[req_tag] = d;
            pend_a[req_tag] = req_addr; pend_s[req_tag] = req_size;
        end
        prev_wait = req_valid && !req_ready; prev_addr = req_addr; prev_wr = req_write;
        exp_mis = n_mis; exp_dead = n_dead; exp_pulse = n_pul; exp_trace = n_trc;
    endtask

    initial begin
        for (int i = 0; i < 3*REG; i++) mem[i] = 8'(i / REG + 1);
        for (int i = 0; i < 4; i++) pend_v[i] = 0;
        rst = 1; port_blocked = 0; req_ready = 1; rsp_valid = 0; rsp_tag = '0; rsp_data = '0;
        prog_interval = IVL; trace_addr = TRACE;
        repeat (3) @(negedge clk);
        // R1 reset state
        chk(!req_valid && rd_count == 0 && wr_count == 0, "R1 reset quiet", {req_valid, rd_count}, 0);
        chk(!mismatch_err && !deadlock_err && !progress_pulse && !trace_hit, "R1 reset flags",
            {mismatch_err, deadlock_err, progress_pulse, trace_hit}, 0);
        rst = 0;
        for (int k = 1; k <= 96; k++) begin
            step(60, 0, 0);
            chk(req_valid == (k == 96), "R1 fill window", req_valid, k == 96);
        end
        for (int k = 0; k < 3000; k++) step(60, 20, 0);
        chk(!mismatch_err, "R5 correct memory raises no mismatch", mismatch_err, 0);
        chk(n_rd * 100 >= n_fire * 55 && n_rd * 100 <= n_fire * 75, "R2 read share", n_rd, n_fire);
        chk(n_uc * 100 >= n_fire * 5 && n_uc * 100 <= n_fire * 16, "R3 uncache share", n_uc, n_fire);
        chk(n_a > 0 && n_b > 0, "R3 both cacheable regions", n_a, n_b);
        chk(n_pulse == bench_rd / IVL, "R11 pulse total", n_pulse, bench_rd / IVL);
        chk(n_trace > 0, "R12 trace seen", n_trace, 1);
        for (int k = 0; k < 600; k++) step(60, 20, 1);
        chk(n_above > 0 && !mismatch_err, "R6 bytes above size ignored", mismatch_err, 0);
        for (int k = 0; k < 600 && !corrupted; k++) step(60, 20, 2);
        step(60, 20, 0);
        chk(mismatch_err == 1'b1, "R6 mismatch raised", mismatch_err, 1);
        repeat (20) step(60, 20, 0);
        chk(mismatch_err == 1'b1, "R6 mismatch sticky", mismatch_err, 1);
        for (int k = 0; k < LIMIT - 50; k++) step(0, 100, 3);
        chk(!deadlock_err, "R13 no early deadlock", deadlock_err, 0);
        repeat (80) step(0, 100, 3);
        chk(deadlock_err == 1'b1, "R13 deadlock while blocked", deadlock_err, 1);
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        finished = 1;
        $finish;
    end

    initial begin
        #(200000 * 5);
        if (!finished) begin
            tests++; fails++;
            $display("FAIL watchdog expired");
            $display("[TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end
endmodule